// File: doc/BRIEF.md
# SMI Timer Unit

This block supplies two timed sources of system-management interrupts for a chipset power-management function. The first is a short software-SMI timer with periods in milliseconds. The second is a long periodic timer with periods of several seconds. Each timer has an enable input and a two-bit rate field that sits inside a configuration word. While a timer is enabled, it counts down on a tick input that pulses once every 0.5 ms. When the count runs out, the timer records its event in a shared status word and sends out an SMI request.

A timer reloads from its current rate field after each expiry, so software may change the rate while the timer runs and the new rate applies from the next period. Software clears status bits by writing ones to them, and only the two timer bits accept such writes. The parameter `TICKS_PER_SEC` sets how many ticks make up one second of the periodic timer. It is 2000 in silicon and can be made small for simulation.

Top module: `smi_timer_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counts, both armed states, the status word and `smi_req` clear to zero.
- R2: The software timer rate is bits 7:6 of `swt_cfg`. Value 0 gives a period of 3 ticks (1.5 ms). A value n of 1 to 3 gives 16·2^n ticks (8·2^n ms). All other bits of `swt_cfg` have no effect.
- R3: The periodic timer rate is bits 1:0 of `pert_cfg`. A value n gives 8·2^(3−n) seconds, which is (8·2^(3−n))·`TICKS_PER_SEC` ticks. All other bits of `pert_cfg` have no effect.
- R4: At a software timer expiry, bit 6 of `sts` is set, every other status bit keeps its value, and `smi_req` is high in the next cycle.
- R5: At a periodic expiry, `sts` becomes 16'h4000, with only bit 14 set and any earlier bits dropped. The one exception is a software expiry in the same cycle, which leaves the status at 16'h4040.
- R6: After an expiry, an enabled timer reloads from the rate field it sees in the expiry cycle. The next expiry then follows after that many ticks.
- R7: The edge at which an enable is first seen high loads a full period, and a tick in that cycle is ignored. The expiry comes at the period-th tick after that edge. A low enable cancels the count, so no expiry occurs until the timer is enabled again.
- R8: A cycle with `sts_wr` high clears each status bit at position 6 or 14 for which `sts_wdata` holds a 1. Zeros in `sts_wdata` and ones at any other position have no effect.
- R9: If a status clear and a set of the same bit fall in one cycle, the bit ends up set.
- R10: `smi_req` is high for exactly one cycle after each cycle that has any expiry. Two timers that expire in the same cycle produce a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle pulse every 0.5 ms |
| swt_cfg | input | 16 | Configuration word holding the software timer rate in bits 7:6 |
| pert_cfg | input | 16 | Configuration word holding the periodic timer rate in bits 1:0 |
| swt_en | input | 1 | Software timer enable |
| pert_en | input | 1 | Periodic timer enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 16 | Status write data; a 1 clears the bit at that position |
| sts | output | 16 | SMI status word |
| smi_req | output | 1 | One-cycle SMI request pulse |

## Verification
On every cycle, the assertions check the following:
- a low enable suppresses expiry;
- an armed load and a reload both take the value from the decoder;
- the count stays within its bound;
- each expiry sets the correct status bit and produces a pulse in the next cycle;
- the periodic expiry overwrites the status word;
- a full-mask write clears the status.

Some behaviours are visible only in the bench scenarios:
- the absolute period that each rate code gives;
- a rate change taking effect at the next reload;
- a fresh count after an enable is cancelled;
- the priority of a set over a clear in the same cycle;
- a single pulse when the two timers expire together.

// File: rtl/smi_timer_pkg.sv
package smi_timer_pkg;
  localparam int STS_W       = 16;
  localparam int SWT_STS_BIT = 6;
  localparam int PER_STS_BIT = 14;
  localparam logic [STS_W-1:0] STS_WMASK =
    (STS_W'(1) << SWT_STS_BIT) | (STS_W'(1) << PER_STS_BIT);

  // Software timer period in 0.5 ms ticks
  function automatic int unsigned swt_period_ticks(input logic [1:0] sel);
    if (sel == 2'd0) return 3;
    return 32'd16 << sel;
  endfunction

  // Periodic timer period in ticks, for tps ticks per second
  function automatic int unsigned per_period_ticks(input logic [1:0] sel,
                                                   input int unsigned tps);
    return (32'd8 << (2'd3 - sel)) * tps;
  endfunction
endpackage

// File: rtl/smi_rate_decode.sv
module smi_rate_decode
  import smi_timer_pkg::*;
#(
  parameter bit          IS_PERIODIC   = 1'b0,
  parameter int unsigned FIELD_LSB     = 6,
  parameter int unsigned TICKS_PER_SEC = 2000,
  parameter int unsigned CNT_W         = 17
) (
  input  logic [15:0]      cfg,
  output logic [CNT_W-1:0] period
);
  logic [1:0] sel;
  assign sel = 2'(cfg >> FIELD_LSB);

  generate
    if (IS_PERIODIC) begin : g_per
      assign period = CNT_W'(per_period_ticks(sel, TICKS_PER_SEC));
    end else begin : g_swt
      assign period = CNT_W'(swt_period_ticks(sel));
    end
  endgenerate
endmodule

// File: rtl/smi_timer_chan.sv
module smi_timer_chan #(
  parameter int unsigned CNT_W     = 17,
  parameter int unsigned MAX_TICKS = 128000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic             en_q;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             arm_evt;

  assign arm_evt = en && !en_q;
  assign expire  = armed && en && en_q && tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (arm_evt) begin
        armed <= 1'b1;
        cnt   <= load_val;
      end else if (armed && tick) begin
        cnt <= expire ? load_val : cnt - CNT_W'(1);
      end
    end
  end

  // R7
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !expire);
  // R7
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> (cnt == $past(load_val)));
  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == $past(load_val)));
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= MAX_TICKS);
endmodule

// File: rtl/smi_status_reg.sv
module smi_status_reg
  import smi_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swt_set,
  input  logic             per_set,
  input  logic             wr,
  input  logic [STS_W-1:0] wdata,
  output logic [STS_W-1:0] sts
);
  localparam logic [STS_W-1:0] SWT_ONE = STS_W'(1) << SWT_STS_BIT;
  localparam logic [STS_W-1:0] PER_ONE = STS_W'(1) << PER_STS_BIT;

  logic [STS_W-1:0] sts_nxt;

  always_comb begin
    sts_nxt = sts;
    if (wr)      sts_nxt = sts_nxt & ~(wdata & STS_WMASK);
    if (per_set) sts_nxt = PER_ONE;
    if (swt_set) sts_nxt = sts_nxt | SWT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= sts_nxt;
  end

  // R4
  swt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swt_set |=> sts[SWT_STS_BIT]);
  // R5
  per_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_set && !swt_set) |=> (sts == PER_ONE));
  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ((wdata & STS_WMASK) == STS_WMASK) && !swt_set && !per_set)
      |=> (sts == '0));
endmodule

// File: rtl/smi_timer_unit.sv
module smi_timer_unit
  import smi_timer_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [15:0] swt_cfg,
  input  logic [15:0] pert_cfg,
  input  logic        swt_en,
  input  logic        pert_en,
  input  logic        sts_wr,
  input  logic [15:0] sts_wdata,
  output logic [15:0] sts,
  output logic        smi_req
);
  localparam int unsigned PER_MAX   = 64 * TICKS_PER_SEC;
  localparam int unsigned MAX_TICKS = (PER_MAX > 128) ? PER_MAX : 128;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] swt_period;
  logic [CNT_W-1:0] per_period;
  logic             swt_expire;
  logic             per_expire;
  logic             any_expire;

  smi_rate_decode #(
    .IS_PERIODIC(1'b0), .FIELD_LSB(6),
    .TICKS_PER_SEC(TICKS_PER_SEC), .CNT_W(CNT_W)
  ) u_swt_dec (.cfg(swt_cfg), .period(swt_period));

  smi_rate_decode #(
    .IS_PERIODIC(1'b1), .FIELD_LSB(0),
    .TICKS_PER_SEC(TICKS_PER_SEC), .CNT_W(CNT_W)
  ) u_per_dec (.cfg(pert_cfg), .period(per_period));

  smi_timer_chan #(.CNT_W(CNT_W), .MAX_TICKS(MAX_TICKS)) u_swt_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(swt_en),
    .load_val(swt_period), .expire(swt_expire)
  );

  smi_timer_chan #(.CNT_W(CNT_W), .MAX_TICKS(MAX_TICKS)) u_per_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(pert_en),
    .load_val(per_period), .expire(per_expire)
  );

  smi_status_reg u_sts (
    .clk(clk), .rst_n(rst_n), .swt_set(swt_expire), .per_set(per_expire),
    .wr(sts_wr), .wdata(sts_wdata), .sts(sts)
  );

  assign any_expire = swt_expire || per_expire;

  always_ff @(posedge clk) begin
    if (!rst_n) smi_req <= 1'b0;
    else        smi_req <= any_expire;
  end

  // R4
  swt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swt_expire |=> (smi_req && sts[SWT_STS_BIT]));
  // R5
  per_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_expire |=> (smi_req && sts[PER_STS_BIT]));
  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_expire |=> !smi_req);
endmodule

// File: tb/test_smi_timer_unit.sv
`timescale 1ns/1ps
module test_smi_timer_unit;
  localparam int unsigned TPS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] swt_cfg = '0;
  logic [15:0] pert_cfg = '0;
  logic        swt_en = 1'b0;
  logic        pert_en = 1'b0;
  logic        sts_wr = 1'b0;
  logic [15:0] sts_wdata = '0;
  logic [15:0] sts;
  logic        smi_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smi_timer_unit #(.TICKS_PER_SEC(TPS)) i_smi_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .swt_cfg(swt_cfg),
    .pert_cfg(pert_cfg), .swt_en(swt_en), .pert_en(pert_en),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts(sts), .smi_req(smi_req)
  );

  function automatic int exp_swt(input int sel);
    return (sel == 0) ? 3 : 2 * 8 * (2 ** sel);
  endfunction

  function automatic int exp_per(input int sel);
    return 8 * (2 ** (3 - sel)) * TPS;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    tick = t;
    @(posedge clk);
    #1;
    tick = 1'b0;
  endtask

  task automatic run_until_smi(output int n, input int limit);
    n = 0;
    do begin
      cyc(1'b1);
      n++;
    end while (!smi_req && n < limit);
  endtask

  task automatic wr_sts(input logic [15:0] d);
    sts_wr = 1'b1;
    sts_wdata = d;
    cyc(1'b0);
    sts_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    int pulses;
    repeat (3) cyc(1'b0);
    check("R1 sts after reset", sts, 0);
    check("R1 smi after reset", smi_req, 0);
    rst_n = 1'b1;
    cyc(1'b0);

    // R2 / R4 / R6 / R10: sweep the software timer rates
    for (int s = 0; s < 4; s++) begin
      wr_sts(16'hFFFF);
      swt_cfg = (16'hA53F & ~16'h00C0) | 16'(s << 6);
      swt_en = 1'b1;
      cyc(1'b0);
      run_until_smi(n, 300);
      check($sformatf("R2 swt period sel %0d", s), n, exp_swt(s));
      check("R4 swt status bit", sts, 16'h0040);
      cyc(1'b0);
      check("R10 pulse one cycle", smi_req, 0);
      run_until_smi(n, 300);
      check($sformatf("R6 swt rearm sel %0d", s), n, exp_swt(s));
      swt_en = 1'b0;
      cyc(1'b0);
    end

    // R6: a rate change applies at the next reload
    swt_cfg = 16'h0040;
    swt_en = 1'b1;
    cyc(1'b0);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin cyc(1'b1); pulses += smi_req; end
    swt_cfg = 16'h0000;
    run_until_smi(n, 300);
    check("R6 current period runs out", n + 10, 32);
    run_until_smi(n, 300);
    check("R6 new rate after reload", n, 3);

    // R7: a low enable cancels the count; re-enabling starts afresh
    swt_en = 1'b0;
    cyc(1'b0);
    swt_en = 1'b1;
    cyc(1'b1);
    cyc(1'b1);
    cyc(1'b1);
    swt_en = 1'b0;
    pulses = 0;
    for (int i = 0; i < 12; i++) begin cyc(1'b1); pulses += smi_req; end
    check("R7 no expiry while disabled", pulses, 0);
    swt_en = 1'b1;
    cyc(1'b1);
    run_until_smi(n, 300);
    check("R7 fresh count after enable", n, 3);
    swt_en = 1'b0;
    cyc(1'b0);

    // R3 / R5: sweep the periodic rates, overwriting a set software bit
    for (int s = 0; s < 4; s++) begin
      check("R4 status before periodic", sts[6], 1);
      pert_cfg = (16'h7E5C & ~16'h0003) | 16'(s);
      pert_en = 1'b1;
      cyc(1'b0);
      run_until_smi(n, 600);
      check($sformatf("R3 periodic period sel %0d", s), n, exp_per(s));
      check("R5 periodic overwrites status", sts, 16'h4000);
      pert_en = 1'b0;
      cyc(1'b0);
      swt_cfg = 16'h0000;
      swt_en = 1'b1;
      cyc(1'b0);
      run_until_smi(n, 300);
      check("R4 swt keeps periodic bit", sts, 16'h4040);
      swt_en = 1'b0;
      cyc(1'b0);
    end

    // R8: write-one-to-clear on the two timer bits only
    wr_sts(16'hBFBF);
    check("R8 zeros and other bits ignored", sts, 16'h4040);
    wr_sts(16'h0040);
    check("R8 clear swt bit", sts, 16'h4000);
    wr_sts(16'h4000);
    check("R8 clear periodic bit", sts, 16'h0000);

    // R9: a set wins over a clear in the same cycle
    swt_en = 1'b1;
    cyc(1'b0);
    cyc(1'b1);
    cyc(1'b1);
    sts_wr = 1'b1;
    sts_wdata = 16'hFFFF;
    cyc(1'b1);
    sts_wr = 1'b0;
    check("R9 set beats clear", sts, 16'h0040);
    check("R9 smi on expiry", smi_req, 1);
    swt_en = 1'b0;
    cyc(1'b0);
    wr_sts(16'hFFFF);

    // R10: both timers expire together and produce one pulse
    swt_cfg = 16'h0040;
    pert_cfg = 16'h0002;
    swt_en = 1'b1;
    pert_en = 1'b1;
    cyc(1'b0);
    run_until_smi(n, 300);
    check("R10 joint expiry time", n, 32);
    check("R5 joint status", sts, 16'h4040);
    cyc(1'b0);
    check("R10 single pulse", smi_req, 0);
    swt_en = 1'b0;
    pert_en = 1'b0;

    // R1: a reset in mid-run clears the status
    rst_n = 1'b0;
    cyc(1'b0);
    check("R1 sts after mid reset", sts, 0);
    check("R1 smi after mid reset", smi_req, 0);
    rst_n = 1'b1;
    pulses = 0;
    for (int i = 0; i < 40; i++) begin cyc(1'b1); pulses += smi_req; end
    check("R1 idle after reset", pulses, 0);

    finish_run();
  end
endmodule